// File: doc/BRIEF.md
# VFD Grid Multiplexer and Dimmer

This block drives the time-shared grid strobes of a vacuum fluorescent display that has either two or three grids sharing one set of 32 anode lines. It divides the base clock into bit times and gives each grid a slot of 2^DIM_W bit times. Within its own slot, each grid's active-low output is pulled low, and the anode outputs show that grid's segment pattern for as long as the brightness window stays open.

The brightness word sets the window length in bit times, counted from the start of the slot. The window is limited to GAP_BITS short of the slot length, so a blank interval always separates the active windows of neighbouring grids. A single level input selects two-grid or three-grid framing. A dimming pulse and two sync pulses (one per slot, one per frame) are provided so that a cascaded slave driver can follow the same timing. Brightness and the three segment patterns are sampled only at slot boundaries.

Top module: `vfd_grid_dimmer`

## Requirements
- R1: One bit time lasts CLK_DIV clock cycles, and a grid slot lasts 2^DIM_W bit times.
- R2: With twoGridMode = 1, a frame is two slots (grid 1, then grid 2). With twoGridMode = 0, a frame is three slots (grid 1, 2, 3). Frames repeat back to back.
- R3: gridN bit g (bit 0 = grid 1) is low only during the first 2^DIM_W − GAP_BITS bit times of slot g. At all other times it is high, and at most one grid is low at once.
- R4: dimOut is high for the first min(dim, 2^DIM_W − GAP_BITS) bit times of every slot, where dim is the captured brightness value.
- R5: A brightness value of 0 keeps dimOut and every segOut bit low for the whole slot.
- R6: During slot g, segOut bit n equals bit n of the pattern for grid g (segGrid1/2/3) while dimOut is high. It is 0 otherwise.
- R7: syncSlot is high for exactly one bit time at the start of every slot. syncFrame is high for one bit time at the start of slot 0 only.
- R8: Brightness and the three segment patterns are captured at the end of each slot. A change in the middle of a slot does not alter the rest of that slot.
- R9: While reset is active, gridN = 3'b110 and segOut, dimOut, syncSlot and syncFrame are 0. The captured brightness resets to 0, so the first slot after reset is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous active-low reset |
| twoGridMode | input | 1 | 1 selects two-grid framing, 0 selects three-grid framing |
| dimLevel | input | DIM_W | Brightness in bit times per slot, clamped to 2^DIM_W − GAP_BITS |
| segGrid1 | input | SEG_W | Segment pattern for grid 1 |
| segGrid2 | input | SEG_W | Segment pattern for grid 2 |
| segGrid3 | input | SEG_W | Segment pattern for grid 3 |
| gridN | output | 3 | Active-low grid strobes, bit 0 = grid 1 |
| segOut | output | SEG_W | Anode outputs, high = lit |
| dimOut | output | 1 | Brightness window, for a slave driver |
| syncSlot | output | 1 | One-bit-time pulse at each slot start |
| syncFrame | output | 1 | One-bit-time pulse at each frame start |

## Verification
The bench builds the block with CLK_DIV = 2, DIM_W = 6 (a 64-bit-time slot) and GAP_BITS = 4. A full three-grid frame is then only 384 cycles long, so every vector can be checked cycle by cycle over a complete frame. With these values the clamp edge (60, 61, 63) and the fixed blanking tail both fall within short runs. A bit time of two cycles also gives the sync-pulse width check a non-trivial length to verify.

// File: rtl/vfd_grid_pkg.sv
package vfd_grid_pkg;

  localparam int GRID_CNT = 3;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic       slotLoad;   // last cycle of a slot: capture shadows
    logic       slotHead;   // bit position 0 of a slot
    logic       frameHead;  // bit position 0 of slot 0
    logic [1:0] slotIdx;    // current grid slot
  } vfd_strobe_t;

endpackage

// File: rtl/vfd_grid_ctrl.sv
module vfd_grid_ctrl
  import vfd_grid_pkg::*;
#(
  parameter int CLK_DIV = 4,
  parameter int DIM_W   = 10
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             twoGridMode,
  output vfd_strobe_t      strobe,
  output logic [DIM_W-1:0] bitPos
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic [DIV_W-1:0] divCnt;
  logic [1:0]       slotIdx;
  logic [1:0]       lastSlot;
  logic             bitTick;
  logic             slotEnd;

  assign bitTick  = (divCnt == DIV_LAST);
  assign slotEnd  = bitTick && (&bitPos);
  assign lastSlot = twoGridMode ? 2'd1 : 2'd2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bitPos  <= '0;
      slotIdx <= '0;
    end else begin
      if (bitTick) begin
        divCnt <= '0;
        bitPos <= bitPos + 1'b1;   // slot length is a power of two
      end else begin
        divCnt <= divCnt + 1'b1;
      end
      if (slotEnd) begin
        slotIdx <= (slotIdx >= lastSlot) ? 2'd0 : slotIdx + 2'd1;
      end
    end
  end

  always_comb begin
    strobe.slotLoad  = slotEnd;
    strobe.slotHead  = (bitPos == '0);
    strobe.frameHead = (bitPos == '0) && (slotIdx == 2'd0);
    strobe.slotIdx   = slotIdx;
  end

endmodule

// File: rtl/vfd_grid_datapath.sv
module vfd_grid_datapath
  import vfd_grid_pkg::*;
#(
  parameter int DIM_W    = 10,
  parameter int GAP_BITS = 8,
  parameter int SEG_W    = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  vfd_strobe_t         strobe,
  input  logic [DIM_W-1:0]    bitPos,
  input  logic [DIM_W-1:0]    dimLevel,
  input  logic [SEG_W-1:0]    segGrid1,
  input  logic [SEG_W-1:0]    segGrid2,
  input  logic [SEG_W-1:0]    segGrid3,
  output logic [GRID_CNT-1:0] gridN,
  output logic [SEG_W-1:0]    segOut,
  output logic                dimOut,
  output logic                syncSlot,
  output logic                syncFrame
);

  localparam int SLOT_BITS = 1 << DIM_W;
  localparam logic [DIM_W-1:0]    MAX_ON   = DIM_W'(SLOT_BITS - GAP_BITS);
  localparam logic [GRID_CNT-1:0] GRID_RST = ~GRID_CNT'(1);

  logic [GRID_CNT-1:0][SEG_W-1:0] segIn;
  logic [GRID_CNT-1:0][SEG_W-1:0] segHold;
  logic [DIM_W-1:0]               dimHold;
  logic [DIM_W-1:0]               dimClamp;
  logic [SEG_W-1:0]               segSel;
  logic [GRID_CNT-1:0]            gridOn;
  logic                           dimOpen;
  logic                           gridOpen;

  assign segIn    = {segGrid3, segGrid2, segGrid1};
  assign dimClamp = (dimLevel > MAX_ON) ? MAX_ON : dimLevel;
  assign dimOpen  = (bitPos < dimHold);
  assign gridOpen = (bitPos < MAX_ON);

  // Shadow registers: refreshed only at a slot boundary.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dimHold <= '0;
      segHold <= '0;
    end else if (strobe.slotLoad) begin
      dimHold <= dimClamp;
      for (int g = 0; g < GRID_CNT; g++) begin
        segHold[g] <= segIn[g];
      end
    end
  end

  for (genvar g = 0; g < GRID_CNT; g++) begin : g_grid
    assign gridOn[g] = (strobe.slotIdx == 2'(g)) && gridOpen;
  end

  always_comb begin
    unique case (strobe.slotIdx)
      2'd0:    segSel = segHold[0];
      2'd1:    segSel = segHold[1];
      2'd2:    segSel = segHold[2];
      default: segSel = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gridN     <= GRID_RST;
      segOut    <= '0;
      dimOut    <= 1'b0;
      syncSlot  <= 1'b0;
      syncFrame <= 1'b0;
    end else begin
      gridN     <= ~gridOn;
      segOut    <= dimOpen ? segSel : '0;
      dimOut    <= dimOpen;
      syncSlot  <= strobe.slotHead;
      syncFrame <= strobe.frameHead;
    end
  end

endmodule

// File: rtl/vfd_grid_dimmer.sv
module vfd_grid_dimmer
  import vfd_grid_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int DIM_W    = 10,
  parameter int GAP_BITS = 8,
  parameter int SEG_W    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             twoGridMode,
  input  logic [DIM_W-1:0] dimLevel,
  input  logic [SEG_W-1:0] segGrid1,
  input  logic [SEG_W-1:0] segGrid2,
  input  logic [SEG_W-1:0] segGrid3,
  output logic [2:0]       gridN,
  output logic [SEG_W-1:0] segOut,
  output logic             dimOut,
  output logic             syncSlot,
  output logic             syncFrame
);

  vfd_strobe_t      strobe;
  logic [DIM_W-1:0] bitPos;

  vfd_grid_ctrl #(
    .CLK_DIV (CLK_DIV),
    .DIM_W   (DIM_W)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .twoGridMode (twoGridMode),
    .strobe      (strobe),
    .bitPos      (bitPos)
  );

  vfd_grid_datapath #(
    .DIM_W    (DIM_W),
    .GAP_BITS (GAP_BITS),
    .SEG_W    (SEG_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .bitPos    (bitPos),
    .dimLevel  (dimLevel),
    .segGrid1  (segGrid1),
    .segGrid2  (segGrid2),
    .segGrid3  (segGrid3),
    .gridN     (gridN),
    .segOut    (segOut),
    .dimOut    (dimOut),
    .syncSlot  (syncSlot),
    .syncFrame (syncFrame)
  );

endmodule

// File: rtl/vfd_grid_dimmer_chk.sv
module vfd_grid_dimmer_chk #(
  parameter int CLK_DIV = 4,
  parameter int SEG_W   = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       gridN,
  input logic [SEG_W-1:0] segOut,
  input logic             dimOut,
  input logic             syncSlot,
  input logic             syncFrame
);

  // Length of the current syncSlot high run, in cycles.
  logic [15:0] runCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         runCnt <= '0;
    else if (syncSlot) runCnt <= runCnt + 16'd1;
    else               runCnt <= '0;
  end

  a_r3_single_grid: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~gridN));

  a_r4_dim_inside_grid: assert property (@(posedge clk) disable iff (!rstN)
    dimOut |-> ($countones(~gridN) == 1));

  a_r6_dark_segments: assert property (@(posedge clk) disable iff (!rstN)
    !dimOut |-> (segOut == '0));

  a_r7_frame_on_slot: assert property (@(posedge clk) disable iff (!rstN)
    syncFrame |-> syncSlot);

  a_r1_sync_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncSlot) |-> (runCnt == 16'(CLK_DIV)));

  a_r8_window_at_slot_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dimOut) |-> $rose(syncSlot));

endmodule

bind vfd_grid_dimmer vfd_grid_dimmer_chk #(
  .CLK_DIV (CLK_DIV),
  .SEG_W   (SEG_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .gridN     (gridN),
  .segOut    (segOut),
  .dimOut    (dimOut),
  .syncSlot  (syncSlot),
  .syncFrame (syncFrame)
);

// File: tb/vfd_grid_dimmer_tb.sv
`timescale 1ns/1ps
module vfd_grid_dimmer_tb;

  localparam int D    = 2;
  localparam int DW   = 6;
  localparam int GAP  = 4;
  localparam int SW   = 32;
  localparam int S    = 1 << DW;
  localparam int NVEC = 8;

  // {twoGridMode, dimLevel, expected lit bit times per slot}
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b0, 6'd30, 6'd30},
    {1'b1, 6'd30, 6'd30},
    {1'b0, 6'd0,  6'd0 },
    {1'b0, 6'd60, 6'd60},
    {1'b0, 6'd61, 6'd60},
    {1'b1, 6'd63, 6'd60},
    {1'b0, 6'd1,  6'd1 },
    {1'b1, 6'd59, 6'd59}
  };

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          twoGridMode = 1'b0;
  logic [DW-1:0] dimLevel = '0;
  logic [SW-1:0] segGrid1 = '0, segGrid2 = '0, segGrid3 = '0;
  logic [2:0]    gridN;
  logic [SW-1:0] segOut;
  logic          dimOut, syncSlot, syncFrame;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;

  always #5 clk = ~clk;

  vfd_grid_dimmer #(
    .CLK_DIV (D), .DIM_W (DW), .GAP_BITS (GAP), .SEG_W (SW)
  ) u_dut (
    .clk (clk), .rstN (rstN), .twoGridMode (twoGridMode), .dimLevel (dimLevel),
    .segGrid1 (segGrid1), .segGrid2 (segGrid2), .segGrid3 (segGrid3),
    .gridN (gridN), .segOut (segOut), .dimOut (dimOut),
    .syncSlot (syncSlot), .syncFrame (syncFrame)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Leaves the bench at the negedge where syncFrame is first seen high.
  task automatic waitFrameStart();
    int guard;
    guard = 0;
    while (syncFrame !== 1'b0 && guard < 4000) begin @(negedge clk); guard++; end
    while (syncFrame !== 1'b1 && guard < 4000) begin @(negedge clk); guard++; end
    if (guard >= 4000) check(1'b0, "R2", "frame start not seen", 0, 1);
  endtask

  // Compares one whole frame against the timing the requirements give.
  task automatic runFrame(input bit two, input int expOn, input logic [SW-1:0] a,
                          input logic [SW-1:0] b, input logic [SW-1:0] c);
    int nSl, fc, eSS, eSF, eG, eD, eSeg;
    longint aG, xG, aS, xS;
    nSl = two ? 2 : 3;
    fc  = nSl * S * D;
    eSS = 0; eSF = 0; eG = 0; eD = 0; eSeg = 0;
    aG = 0; xG = 0; aS = 0; xS = 0;
    for (int i = 0; i < fc; i++) begin
      int sl, pos;
      logic [2:0]    xg;
      logic          xd;
      logic [SW-1:0] lat, xs;
      sl  = i / (S * D);
      pos = (i % (S * D)) / D;
      xg  = (pos < S - GAP) ? ~(3'b001 << sl) : 3'b111;
      xd  = (pos < expOn);
      lat = (sl == 0) ? a : (sl == 1) ? b : c;
      xs  = xd ? lat : '0;
      if (syncSlot !== (pos == 0)) eSS++;
      if (syncFrame !== (pos == 0 && sl == 0)) eSF++;
      if (gridN !== xg) begin eG++; aG = gridN; xG = xg; end
      if (dimOut !== xd) eD++;
      if (segOut !== xs) begin eSeg++; aS = segOut; xS = xs; end
      @(negedge clk);
    end
    check(eSS == 0, "R1", "syncSlot pattern mismatches", eSS, 0);
    check(eSF == 0, "R7", "syncFrame pattern mismatches", eSF, 0);
    check(eG == 0, "R3", "grid strobe", aG, xG);
    check(eD == 0, "R4", "dim window mismatches", eD, 0);
    check(eSeg == 0, (expOn == 0) ? "R5" : "R6", "segment output", aS, xS);
    check(syncFrame === 1'b1, "R2", "next frame start after slots", syncFrame, 1);
  endtask

  initial begin
    int cnt, bad;
    logic [SW-1:0] pa;

    // R9: reset values, with a nonzero brightness already on the input
    dimLevel = 6'd20;
    segGrid1 = 32'hFFFF_FFFF;
    repeat (4) @(negedge clk);
    check(gridN === 3'b110, "R9", "gridN in reset", gridN, 3'b110);
    check(segOut === '0, "R9", "segOut in reset", segOut, 0);
    check({dimOut, syncSlot, syncFrame} === 3'b000, "R9", "pulses in reset",
          {dimOut, syncSlot, syncFrame}, 0);
    rstN = 1'b1;
    cnt = 0;
    repeat (S * D) begin @(negedge clk); if (dimOut) cnt++; end
    check(cnt == 0, "R9", "lit cycles in first slot after reset", cnt, 0);
    cnt = 0;
    repeat (S * D) begin @(negedge clk); if (dimOut) cnt++; end
    check(cnt == 20 * D, "R8", "lit cycles in second slot", cnt, 20 * D);

    // Vector table
    for (int v = 0; v < NVEC; v++) begin
      logic [SW-1:0] a, b, c;
      a = 32'hF0F0_1234 ^ (32'h0101_0101 * 32'(v));
      b = ~a;
      c = {a[15:0], a[31:16]};
      twoGridMode = VEC[v][12];
      dimLevel    = VEC[v][11:6];
      segGrid1 = a; segGrid2 = b; segGrid3 = c;
      waitFrameStart();
      runFrame(VEC[v][12], int'(VEC[v][5:0]), a, b, c);
    end

    // R8: mid-slot change of brightness and pattern
    twoGridMode = 1'b0;
    pa = 32'h1357_9BDF;
    dimLevel = 6'd10;
    segGrid1 = pa;
    waitFrameStart();
    cnt = 0; bad = 0;
    for (int i = 0; i < S * D; i++) begin
      if (dimOut) begin cnt++; if (segOut !== pa) bad++; end
      if (i == 5) begin dimLevel = 6'd40; segGrid1 = ~pa; end
      @(negedge clk);
    end
    check(cnt == 10 * D, "R8", "lit cycles after mid-slot change", cnt, 10 * D);
    check(bad == 0, "R8", "pattern changed mid-slot", bad, 0);
    cnt = 0;
    for (int i = 0; i < S * D; i++) begin
      if (dimOut) cnt++;
      @(negedge clk);
    end
    check(cnt == 40 * D, "R8", "lit cycles in following slot", cnt, 40 * D);
    waitFrameStart();
    check(segOut === ~pa, "R8", "new grid 1 pattern next frame", segOut, ~pa);

    // R9: reset in the middle of a run
    repeat (37) @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(gridN === 3'b110 && segOut === '0 && !dimOut && !syncFrame, "R9",
          "outputs after mid-run reset", {gridN, dimOut, syncFrame}, 3'b110 << 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule